// File: doc/BRIEF.md
# Three-Wire Serial Wiper Control Port

This block is the digital control logic of a dual digital potentiometer with 256 taps per element. A host drives three lines: an active-high select, a serial clock and a serial data line. While the select is high, every rising edge of the serial clock moves one data bit into a 17-stage frame register. When the select drops, the frame is copied into registered outputs: one stack-select bit and two 8-bit wiper tap codes, which feed the tap decoders of the resistor ladders.

The three lines are oversampled by the system clock through a synchronizer. Raising the select preloads the frame register with the stored settings. The last stage of the frame register drives a cascade output, so the bits that are shifted out read the stored settings back to the host. The same output can feed the data line of a second device on the same bus, and the register then acts as a 17-bit delay line.

Top module: `dpot_serial_ctl`

## Requirements
- R1: While rst_n is low, wiper_o, stack_o and cascade_o are all zero.
- R2: While sel_i is low, edges on sclk_i and values on sdata_i change neither the outputs nor the frame register, and cascade_o holds its value.
- R3: A low-to-high transition of sel_i loads the frame register from the current settings, so cascade_o first shows stack_o. The next serial clocks then present the pot-1 code MSB first, followed by the pot-0 code MSB first.
- R4: While sel_i stays high, each rising edge of sclk_i shifts sdata_i into the frame register. The first of 17 bits clocked in becomes the stack-select bit.
- R5: Frame layout: frame bit 0 is the stack select. Bits 1..8 are pot 1 (wiper_o[15:8]) with its MSB in bit 1. Bits 9..16 are pot 0 (wiper_o[7:0]) with its MSB in bit 9.
- R6: wiper_o and stack_o change only on a high-to-low transition of sel_i, never during shifting.
- R7: cascade_o presents the bit held in the last of the 17 stages. A bit clocked in on one rising edge of sclk_i is shown on cascade_o after sixteen more rising edges.
- R8: A transfer with fewer or more than 17 clocks latches the register contents as they stand. After a long transfer the outputs hold the last 17 bits, and after a short one the outputs hold the shifted preload.
- R9: With the default two synchronizer stages, a change on an input line affects the outputs on the third rising edge of clk after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sel_i | input | 1 | Serial port select, active high |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdata_i | input | 1 | Serial data in |
| wiper_o | output | 16 | Wiper codes, pot 1 in [15:8], pot 0 in [7:0] |
| stack_o | output | 1 | Stack-select setting |
| cascade_o | output | 1 | Bit leaving the frame register (readback and daisy-chain) |

## Verification
The bound checker checks the following on every cycle:
- At most one serial event occurs per cycle.
- The frame register is frozen while the synchronized select is low.
- Each shift puts the data bit in the last-in stage and advances the cascade output.
- A preload puts the stored stack bit on the cascade output.
- A latch copies the right frame bits into the outputs.
- The outputs hold in every cycle without a latch.

Only the bench scenarios can show the rest. These are the full bit order of readback, the value that a short or an over-long transfer leaves behind, and the 17-clock delay seen on the cascade output. They also include the exact latency from a select edge to the outputs.

// File: rtl/dpot_ctl_pkg.sv
package dpot_ctl_pkg;

    // Events decoded from the synchronized serial lines.
    typedef struct packed {
        logic load;   // select rose: preload stored settings
        logic shift;  // serial clock rose while selected
        logic latch;  // select fell: publish the frame
        logic data;   // synchronized serial data
    } serial_evt_t;

    // Lowest frame index of a pot field; higher pot numbers sit nearer bit 0.
    function automatic int field_base(input int pot, input int num_pots, input int wiper_w);
        return 1 + (num_pots - 1 - pot) * wiper_w;
    endfunction

endpackage

// File: rtl/dpot_in_sync.sv
module dpot_in_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];
    assign prev_o = st_q.prev;

endmodule

// File: rtl/dpot_evt_decode.sv
module dpot_evt_decode
    import dpot_ctl_pkg::*;
(
    input  logic        sel_s,
    input  logic        sel_p,
    input  logic        sck_s,
    input  logic        sck_p,
    input  logic        dat_s,
    output serial_evt_t evt_o
);

    always_comb begin
        evt_o.load  = sel_s & ~sel_p;
        evt_o.latch = ~sel_s & sel_p;
        evt_o.shift = sel_s & sel_p & sck_s & ~sck_p;
        evt_o.data  = dat_s;
    end

endmodule

// File: rtl/dpot_frame_sr.sv
module dpot_frame_sr
    import dpot_ctl_pkg::*;
#(
    parameter int WIPER_W  = 8,
    parameter int NUM_POTS = 2,
    localparam int FRAME_W = 1 + NUM_POTS * WIPER_W,
    localparam int CODES_W = NUM_POTS * WIPER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  serial_evt_t        evt_i,
    input  logic [CODES_W-1:0] wiper_i,
    input  logic               stack_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               cascade_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
    } sr_state_t;

    sr_state_t          sr_d, sr_q;
    logic [FRAME_W-1:0] preload;

    assign preload[0] = stack_i;

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pack_pot
        localparam int BASE = field_base(p, NUM_POTS, WIPER_W);
        for (genvar i = 0; i < WIPER_W; i++) begin : g_pack_bit
            assign preload[BASE + i] = wiper_i[p*WIPER_W + WIPER_W - 1 - i];
        end
    end

    always_comb begin
        sr_d = sr_q;
        if (evt_i.load) begin
            sr_d.bits = preload;
        end else if (evt_i.shift) begin
            sr_d.bits = {evt_i.data, sr_q.bits[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign frame_o   = sr_q.bits;
    assign cascade_o = sr_q.bits[0];

endmodule

// File: rtl/dpot_wiper_regs.sv
module dpot_wiper_regs
    import dpot_ctl_pkg::*;
#(
    parameter int WIPER_W  = 8,
    parameter int NUM_POTS = 2,
    localparam int FRAME_W = 1 + NUM_POTS * WIPER_W,
    localparam int CODES_W = NUM_POTS * WIPER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               latch_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [CODES_W-1:0] wiper_o,
    output logic               stack_o
);

    typedef struct packed {
        logic [CODES_W-1:0] codes;
        logic               stack;
    } wiper_state_t;

    wiper_state_t       ws_d, ws_q;
    logic [CODES_W-1:0] unpacked;

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_unpack_pot
        localparam int BASE = field_base(p, NUM_POTS, WIPER_W);
        for (genvar i = 0; i < WIPER_W; i++) begin : g_unpack_bit
            assign unpacked[p*WIPER_W + WIPER_W - 1 - i] = frame_i[BASE + i];
        end
    end

    always_comb begin
        ws_d = ws_q;
        if (latch_i) begin
            ws_d.codes = unpacked;
            ws_d.stack = frame_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q <= '0;
        end else begin
            ws_q <= ws_d;
        end
    end

    assign wiper_o = ws_q.codes;
    assign stack_o = ws_q.stack;

endmodule

// File: rtl/dpot_serial_ctl.sv
module dpot_serial_ctl
    import dpot_ctl_pkg::*;
#(
    parameter int WIPER_W     = 8,
    parameter int NUM_POTS    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int FRAME_W    = 1 + NUM_POTS * WIPER_W,
    localparam int CODES_W    = NUM_POTS * WIPER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               sclk_i,
    input  logic               sdata_i,
    output logic [CODES_W-1:0] wiper_o,
    output logic               stack_o,
    output logic               cascade_o
);

    logic [2:0]         line_s;
    logic [2:0]         line_p;
    logic               unused_data_prev;
    serial_evt_t        evt;
    logic               ev_load, ev_shift, ev_latch, ev_data;
    logic [FRAME_W-1:0] frame;

    dpot_in_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (3)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdata_i, sclk_i, sel_i}),
        .sync_o  (line_s),
        .prev_o  (line_p)
    );

    assign unused_data_prev = line_p[2];

    dpot_evt_decode u_decode (
        .sel_s (line_s[0]),
        .sel_p (line_p[0]),
        .sck_s (line_s[1]),
        .sck_p (line_p[1]),
        .dat_s (line_s[2]),
        .evt_o (evt)
    );

    assign ev_load  = evt.load;
    assign ev_shift = evt.shift;
    assign ev_latch = evt.latch;
    assign ev_data  = evt.data;

    dpot_frame_sr #(
        .WIPER_W  (WIPER_W),
        .NUM_POTS (NUM_POTS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .wiper_i   (wiper_o),
        .stack_i   (stack_o),
        .frame_o   (frame),
        .cascade_o (cascade_o)
    );

    dpot_wiper_regs #(
        .WIPER_W  (WIPER_W),
        .NUM_POTS (NUM_POTS)
    ) u_wipers (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch_i (evt.latch),
        .frame_i (frame),
        .wiper_o (wiper_o),
        .stack_o (stack_o)
    );

endmodule

// File: rtl/dpot_serial_ctl_chk.sv
module dpot_serial_ctl_chk #(
    parameter int WIPER_W  = 8,
    parameter int NUM_POTS = 2,
    localparam int FRAME_W = 1 + NUM_POTS * WIPER_W,
    localparam int CODES_W = NUM_POTS * WIPER_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sel_s,
    input logic               ev_load,
    input logic               ev_shift,
    input logic               ev_latch,
    input logic               ev_data,
    input logic [FRAME_W-1:0] frame,
    input logic [CODES_W-1:0] wiper_o,
    input logic               stack_o,
    input logic               cascade_o
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (wiper_o == '0 && !stack_o && !cascade_o));

    assert_idle_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> $stable(frame));

    assert_preload_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_load |=> (cascade_o == $past(stack_o)) && (frame[FRAME_W-1] == $past(wiper_o[0])));

    assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_shift |=> (frame[FRAME_W-1] == $past(ev_data)) && (cascade_o == $past(frame[1])));

    assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_load, ev_shift, ev_latch}));

    assert_latch_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_latch |=> (stack_o == $past(frame[0]))
                  && (wiper_o[CODES_W-1] == $past(frame[1]))
                  && (wiper_o[0] == $past(frame[FRAME_W-1])));

    assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_latch |=> $stable(wiper_o) && $stable(stack_o));

endmodule

bind dpot_serial_ctl dpot_serial_ctl_chk #(
    .WIPER_W  (WIPER_W),
    .NUM_POTS (NUM_POTS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (line_s[0]),
    .ev_load   (ev_load),
    .ev_shift  (ev_shift),
    .ev_latch  (ev_latch),
    .ev_data   (ev_data),
    .frame     (frame),
    .wiper_o   (wiper_o),
    .stack_o   (stack_o),
    .cascade_o (cascade_o)
);

// File: tb/dpot_serial_ctl_bench.sv
module dpot_serial_ctl_bench;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic [15:0] wiper_o;
    logic        stack_o;
    logic        cascade_o;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dpot_serial_ctl u_dpot_serial_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .sclk_i    (sclk),
        .sdata_i   (sdata),
        .wiper_o   (wiper_o),
        .stack_o   (stack_o),
        .cascade_o (cascade_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0] pipe[$];
    logic [2:0] m_prev;
    bit         mq[$];
    int         m_w1, m_w0;
    bit         m_stack;

    function automatic void model_step(input logic [2:0] cur, input logic [2:0] prv);
        // bit 0 select, bit 1 serial clock, bit 2 data
        if (cur[0] && !prv[0]) begin
            mq.delete();
            mq.push_back(m_stack);
            for (int i = 7; i >= 0; i--) mq.push_back(bit'((m_w1 >> i) & 1));
            for (int i = 7; i >= 0; i--) mq.push_back(bit'((m_w0 >> i) & 1));
        end else if (!cur[0] && prv[0]) begin
            m_stack = mq[0];
            m_w1 = 0;
            m_w0 = 0;
            for (int i = 0; i < 8; i++) begin
                m_w1 = (m_w1 << 1) | int'(mq[1+i]);
                m_w0 = (m_w0 << 1) | int'(mq[9+i]);
            end
        end else if (cur[0] && cur[1] && !prv[1]) begin
            void'(mq.pop_front());
            mq.push_back(cur[2]);
        end
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            pipe.delete();
            m_prev = 3'b000;
            mq.delete();
            for (int i = 0; i < 17; i++) mq.push_back(1'b0);
            m_w1 = 0;
            m_w0 = 0;
            m_stack = 1'b0;
        end else begin
            pipe.push_back({sdata, sclk, sel});
            if (pipe.size() >= 3) begin
                logic [2:0] cur;
                cur = pipe.pop_front();
                model_step(cur, m_prev);
                m_prev = cur;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 model wiper", int'(wiper_o), (m_w1 << 8) | m_w0);
            chk("R6 model stack", int'(stack_o), int'(m_stack));
            chk("R7 model cascade", int'(cascade_o), int'(mq[0]));
        end
    end

    // ---------------- stimulus helpers ----------------
    bit last_cap[$];

    function automatic void build_frame(input bit st, input int w1, input int w0, ref bit q[$]);
        q.delete();
        q.push_back(st);
        for (int i = 7; i >= 0; i--) q.push_back(bit'((w1 >> i) & 1));
        for (int i = 7; i >= 0; i--) q.push_back(bit'((w0 >> i) & 1));
    endfunction

    function automatic int pack_bits(ref bit q[$], input int first, input int count);
        int v = 0;
        for (int i = 0; i < count; i++) v = (v << 1) | int'(q[first+i]);
        return v;
    endfunction

    task automatic send(ref bit b[$], input int old_w, input int new_w, input bit new_st, input string tag);
        last_cap.delete();
        @(negedge clk);
        sel = 1'b1;
        sclk = 1'b0;
        foreach (b[i]) begin
            sdata = b[i];
            repeat (HALF) @(negedge clk);
            last_cap.push_back(cascade_o);
            if (i == 9) chk("R6 outputs hold mid-transfer", int'(wiper_o), old_w);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        sel = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 unchanged two clocks after select fall", int'(wiper_o), old_w);
        @(negedge clk);
        chk({tag, " wiper after latch"}, int'(wiper_o), new_w);
        chk({tag, " stack after latch"}, int'(stack_o), int'(new_st));
        repeat (4) @(negedge clk);
    endtask

    task automatic idle_toggle();
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            sclk = ~sclk;
            sdata = k[0];
        end
        sclk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        bit fa[$];
        bit fb[$];
        bit fs[$];
        bit fl[$];
        bit exp_rb[$];

        repeat (3) @(negedge clk);
        chk("R1 reset wiper", int'(wiper_o), 0);
        chk("R1 reset stack", int'(stack_o), 0);
        chk("R1 reset cascade", int'(cascade_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        idle_toggle();
        chk("R2 idle wiper from reset", int'(wiper_o), 0);
        chk("R2 idle cascade from reset", int'(cascade_o), 0);

        // Frame A: stack 1, pot1 A5, pot0 3C
        build_frame(1'b1, 'hA5, 'h3C, fa);
        send(fa, 'h0000, 'hA53C, 1'b1, "R4 R5 frame A");
        chk("R3 readback of reset settings", pack_bits(last_cap, 0, 17), 0);

        idle_toggle();
        chk("R2 idle keeps wiper", int'(wiper_o), 'hA53C);
        chk("R2 idle keeps cascade", int'(cascade_o), 1);

        // Frame B: stack 0, pot1 01, pot0 80
        build_frame(1'b0, 'h01, 'h80, fb);
        send(fb, 'hA53C, 'h0180, 1'b0, "R5 frame B");
        chk("R3 readback of frame A", pack_bits(last_cap, 0, 17), pack_bits(fa, 0, 17));

        // Short transfer of 5 bits: preload B shifted by five
        fs = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
        send(fs, 'h0180, 'h301B, 1'b0, "R8 short transfer");

        // Long transfer: 3 leading bits then frame C (stack 1, 5A, C3)
        build_frame(1'b1, 'h5A, 'hC3, fl);
        fl.push_front(1'b1);
        fl.push_front(1'b0);
        fl.push_front(1'b1);
        send(fl, 'h301B, 'h5AC3, 1'b1, "R8 long transfer");
        build_frame(1'b0, 'h30, 'h1B, exp_rb);
        chk("R3 readback after short transfer", pack_bits(last_cap, 0, 17), pack_bits(exp_rb, 0, 17));
        chk("R7 leading bits leave after 17 clocks", pack_bits(last_cap, 17, 3), 'b101);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule